// File: doc/BRIEF.md
# Byte-Accessed 16-Bit Timer with Atomic Access

This block is a 16-bit up-counter with a selectable prescaler. An 8-bit processor reaches it through four byte registers: the counter's low byte, its high byte, a control register and an overflow flag register. The counter advances on enabled ticks of `cnt_en_i`, which stands in for an external or secondary clock source sampled in the block's clock domain.

With buffered mode off, the high-byte address reaches the live counter high byte directly. With buffered mode on, the high-byte address reaches a shadow latch instead. Reading the low byte fills the latch with the live high byte in the same access. Writing the low byte commits the latch to the live high byte in the same cycle. Software can then read or write all 16 bits as one consistent value, even when the counter rolls over between the two byte accesses.

A rollover from 0xFFFF to 0x0000 sets a sticky overflow flag, which software clears with a dedicated write. The control register also holds an oscillator-enable bit that drives an output pin, and a read-only status bit that reports whether the timer's oscillator is supplying the system clock.

Top module: `byte_timer`

## Requirements
- R1: After reset the counter, the shadow latch, the control register and the overflow flag are all zero. Every register reads 0x00 and `ovf_o` is low.
- R2: Register addresses are low byte 0, high byte 1, control 2 and flag 3. With control bit 7 clear, the high-byte address reads and writes the live counter high byte directly.
- R3: With control bit 7 set, a read of address 0 copies the live high byte into the shadow latch on that access. Later reads of address 1 return the shadow value, even if the counter has since carried into its high byte.
- R4: With control bit 7 set, a write to address 1 changes only the shadow latch. A write to address 0 loads the written byte into the low byte and the shadow latch into the high byte in the same cycle.
- R5: Control bit 0 enables counting. Control bits 5:4 select a prescale ratio of 1, 2, 4 or 8 (values 0 to 3). The counter advances once for every ratio-many cycles in which `cnt_en_i` is high and bit 0 is set. While bit 0 is clear, the prescaler holds its state.
- R6: A write to address 0 clears the prescaler. A write to address 1 leaves the prescaler unchanged.
- R7: An increment from 0xFFFF to 0x0000 sets the overflow flag, which reads as bit 0 of address 3 and drives `ovf_o`. The flag stays set until a write to address 3 with data bit 0 set. A write with data bit 0 clear leaves the flag unchanged.
- R8: Control bit 3 is writable and drives `osc_en_o`. Control bit 6 reads the value of `osc_active_i`, and writes to it are ignored. Control bits 2:1 always read as zero.
- R9: When a counter byte write and a prescaled increment fall in the same cycle, the written value is kept and the increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Count tick from the external or secondary source |
| osc_active_i | input | 1 | High while the timer oscillator supplies the system clock |
| addr_i | input | 2 | Register select: 0 low byte, 1 high byte, 2 control, 3 flag |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register, combinational |
| osc_en_o | output | 1 | Oscillator enable (control bit 3) |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
On every cycle, the assertions check the following behaviours:
- a buffered low-byte read loads the shadow latch with the live high byte;
- a buffered low-byte write commits the shadow latch to the high byte;
- a counter byte write wins over a same-cycle increment;
- a wrap sets the flag;
- the prescaler clears when the low byte is written and gives no tick without an enable.

Only the bench scenarios can show the following:
- the register-level views, such as a stale shadow value after a carry into the high byte;
- the exact tick counts for each prescale ratio;
- a prescaler phase that survives a high-byte write and a timer-off period;
- the flag's clear-on-write-one behaviour.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    REG_LO  = 2'd0,
    REG_HI  = 2'd1,
    REG_CTL = 2'd2,
    REG_FLG = 2'd3
  } reg_sel_e;

  localparam int unsigned PS_SEL_W  = 2;
  localparam int unsigned CTL_BUF   = 7;
  localparam int unsigned CTL_STAT  = 6;
  localparam int unsigned CTL_PS_LO = 4;
  localparam int unsigned CTL_OSC   = 3;
  localparam int unsigned CTL_ON    = 0;
  // writable control bits: 7, 5, 4, 3, 0
  localparam logic [7:0]  CTL_WMASK = 8'hB9;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask   = (DIV_W'(1) << sel_i) - DIV_W'(1);
  assign tick_o = en_i && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (clr_i) div_q <= '0;
    else if (en_i)  div_q <= div_q + DIV_W'(1);
  end

  a_r6_clear_on_low_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> div_q == '0);
  a_r5_no_tick_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick_o);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               wr_lo_i,
  input  logic               wr_hi_i,
  input  logic [CNT_W/2-1:0] lo_d_i,
  input  logic [CNT_W/2-1:0] hi_d_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               wrap_o
);
  localparam int unsigned HW = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q;
  logic             any_wr;

  assign any_wr = wr_lo_i || wr_hi_i;
  assign wrap_o = tick_i && !any_wr && (&cnt_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (any_wr) begin
      // a write wins; the increment of this cycle is lost
      if (wr_lo_i) cnt_q[HW-1:0]     <= lo_d_i;
      if (wr_hi_i) cnt_q[CNT_W-1:HW] <= hi_d_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  a_r9_write_beats_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && tick_i) |=> cnt_q[HW-1:0] == $past(lo_d_i));
endmodule

// File: rtl/byte_timer.sv
module byte_timer
  import tmr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              osc_active_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              osc_en_o,
  output logic              ovf_o
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] ctl_q, shadow_q;
  logic              ovf_q;
  logic [CNT_W-1:0]  cnt;
  logic              tick, wrap;
  logic              buf_mode;
  logic              wr_lo, wr_hi_reg, wr_ctl, wr_flg, rd_lo;
  logic              core_wr_hi;
  logic [BYTE_W-1:0] core_hi_d;
  logic [BYTE_W-1:0] cnt_hi;

  assign buf_mode  = ctl_q[CTL_BUF];
  assign wr_lo     = wr_i && (addr_i == REG_LO);
  assign wr_hi_reg = wr_i && (addr_i == REG_HI);
  assign wr_ctl    = wr_i && (addr_i == REG_CTL);
  assign wr_flg    = wr_i && (addr_i == REG_FLG);
  assign rd_lo     = rd_i && (addr_i == REG_LO);
  assign cnt_hi    = cnt[CNT_W-1:BYTE_W];

  // buffered: high byte committed from the shadow on a low write
  assign core_wr_hi = buf_mode ? wr_lo : wr_hi_reg;
  assign core_hi_d  = buf_mode ? shadow_q : wdata_i;

  tmr_prescaler #(.SEL_W(PS_SEL_W)) u_ps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cnt_en_i && ctl_q[CTL_ON]),
    .clr_i  (wr_lo),
    .sel_i  (ctl_q[CTL_PS_LO +: PS_SEL_W]),
    .tick_o (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .wr_lo_i (wr_lo),
    .wr_hi_i (core_wr_hi),
    .lo_d_i  (wdata_i),
    .hi_d_i  (core_hi_d),
    .cnt_o   (cnt),
    .wrap_o  (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   shadow_q <= '0;
    else if (buf_mode && wr_hi_reg) shadow_q <= wdata_i;
    else if (buf_mode && rd_lo)     shadow_q <= cnt_hi;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= '0;
    else if (wr_ctl) ctl_q <= wdata_i & BYTE_W'(CTL_WMASK);
  end

  // a wrap in the same cycle as a clear keeps the flag set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ovf_q <= 1'b0;
    else if (wrap)                 ovf_q <= 1'b1;
    else if (wr_flg && wdata_i[0]) ovf_q <= 1'b0;
  end

  always_comb begin
    unique case (addr_i)
      REG_LO:  rdata_o = cnt[BYTE_W-1:0];
      REG_HI:  rdata_o = buf_mode ? shadow_q : cnt_hi;
      REG_CTL: begin
        rdata_o = ctl_q;
        rdata_o[CTL_STAT] = osc_active_i;
      end
      default: rdata_o = BYTE_W'(ovf_q);
    endcase
  end

  assign osc_en_o = ctl_q[CTL_OSC];
  assign ovf_o    = ovf_q;

  a_r3_shadow_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_mode && rd_lo) |=> shadow_q == $past(cnt_hi));
  a_r4_atomic_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_mode && wr_lo) |=> (cnt_hi == $past(shadow_q)) && (cnt[BYTE_W-1:0] == $past(wdata_i)));
  a_r7_wrap_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> ovf_o);
  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !(wr_flg && wdata_i[0])) |=> ovf_o);
endmodule

// File: tb/byte_timer_tb.sv
`timescale 1ns/1ps
module byte_timer_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cnt_en = 1'b0;
  logic       osc_active = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       osc_en, ovf;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  byte_timer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_en_i(cnt_en), .osc_active_i(osc_active),
    .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata),
    .osc_en_o(osc_en), .ovf_o(ovf)
  );

  // {is_write, addr, data, expected read}
  localparam int NV = 20;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 2'd2, 8'h00, 8'h00},
    {1'b1, 2'd0, 8'h34, 8'h00},
    {1'b1, 2'd1, 8'h12, 8'h00},
    {1'b0, 2'd0, 8'h00, 8'h34},
    {1'b0, 2'd1, 8'h00, 8'h12},
    {1'b1, 2'd2, 8'h80, 8'h00},
    {1'b0, 2'd2, 8'h00, 8'h80},
    {1'b1, 2'd1, 8'hAB, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'hAB},
    {1'b0, 2'd0, 8'h00, 8'h34},
    {1'b0, 2'd1, 8'h00, 8'h12},
    {1'b1, 2'd1, 8'h56, 8'h00},
    {1'b1, 2'd0, 8'h78, 8'h00},
    {1'b1, 2'd2, 8'h00, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h56},
    {1'b0, 2'd0, 8'h00, 8'h78},
    {1'b1, 2'd2, 8'hC6, 8'h00},
    {1'b0, 2'd2, 8'h00, 8'h80},
    {1'b1, 2'd2, 8'h08, 8'h00},
    {1'b0, 2'd2, 8'h00, 8'h08}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
    addr = a; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 ovf_o", {7'd0, ovf}, 8'h00);
    for (int a = 0; a < 4; a++) begin
      bus_rd(2'(a), v);
      chk("R1 reg", v, 8'h00);
    end

    // table: R2 R3 R4 R8 register views with the timer stopped
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][18]) begin
        bus_wr(VEC[i][17:16], VEC[i][15:8]);
      end else begin
        bus_rd(VEC[i][17:16], v);
        chk($sformatf("table R2 R3 R4 R8 step %0d", i), v, VEC[i][7:0]);
      end
    end
    chk("R8 osc_en_o", {7'd0, osc_en}, 8'h01);

    // R5 prescale ratios and gating
    bus_wr(2'd2, 8'h01); bus_wr(2'd1, 8'h00); bus_wr(2'd0, 8'h00);
    pulse(5);  bus_rd(2'd0, v); chk("R5 ratio1", v, 8'h05);
    bus_wr(2'd2, 8'h11); bus_wr(2'd0, 8'h00);
    pulse(6);  bus_rd(2'd0, v); chk("R5 ratio2", v, 8'h03);
    bus_wr(2'd2, 8'h31); bus_wr(2'd0, 8'h00);
    pulse(16); bus_rd(2'd0, v); chk("R5 ratio8", v, 8'h02);
    pulse(7);  bus_rd(2'd0, v); chk("R5 ratio8 partial", v, 8'h02);
    bus_wr(2'd2, 8'h30);
    pulse(8);  bus_rd(2'd0, v); chk("R5 timer off", v, 8'h02);
    bus_wr(2'd2, 8'h31);
    pulse(1);  bus_rd(2'd0, v); chk("R5 prescaler held while off", v, 8'h03);
    bus_rd(2'd1, v); chk("R5 high byte", v, 8'h00);

    // R6 prescaler clear rules (ratio 8)
    bus_wr(2'd0, 8'h00);
    pulse(4); bus_wr(2'd1, 8'h00);
    pulse(4); bus_rd(2'd0, v); chk("R6 high write keeps prescaler", v, 8'h01);
    pulse(4); bus_wr(2'd0, 8'h10);
    pulse(4); bus_rd(2'd0, v); chk("R6 low write clears prescaler", v, 8'h10);
    pulse(4); bus_rd(2'd0, v); chk("R6 tick after clear", v, 8'h11);

    // R7 overflow flag
    bus_wr(2'd2, 8'h01); bus_wr(2'd1, 8'hFF); bus_wr(2'd0, 8'hFE);
    pulse(1); bus_rd(2'd0, v); chk("R7 at ffff", v, 8'hFF);
    chk("R7 no flag before wrap", {7'd0, ovf}, 8'h00);
    pulse(1);
    chk("R7 ovf_o after wrap", {7'd0, ovf}, 8'h01);
    bus_rd(2'd3, v); chk("R7 flag reg", v, 8'h01);
    bus_rd(2'd1, v); chk("R7 wrapped high", v, 8'h00);
    bus_rd(2'd0, v); chk("R7 wrapped low", v, 8'h00);
    pulse(3); bus_rd(2'd3, v); chk("R7 sticky", v, 8'h01);
    bus_wr(2'd3, 8'h00); bus_rd(2'd3, v); chk("R7 write zero keeps", v, 8'h01);
    bus_wr(2'd3, 8'h01); bus_rd(2'd3, v); chk("R7 cleared", v, 8'h00);

    // R9 write beats a same-cycle increment
    addr = 2'd0; wdata = 8'h40; wr = 1'b1; cnt_en = 1'b1;
    @(negedge clk);
    wr = 1'b0; cnt_en = 1'b0;
    bus_rd(2'd0, v); chk("R9 write wins", v, 8'h40);

    // R3 shadow stays stale across a carry
    bus_wr(2'd2, 8'h81); bus_wr(2'd1, 8'h00); bus_wr(2'd0, 8'hFF);
    bus_rd(2'd0, v); chk("R3 low read", v, 8'hFF);
    pulse(1);
    bus_rd(2'd1, v); chk("R3 stale shadow", v, 8'h00);
    bus_rd(2'd0, v); chk("R3 low after carry", v, 8'h00);
    bus_rd(2'd1, v); chk("R3 recaptured", v, 8'h01);

    // R8 status and oscillator enable
    osc_active = 1'b1;
    bus_rd(2'd2, v); chk("R8 status bit", v, 8'hC1);
    chk("R8 osc_en_o off", {7'd0, osc_en}, 8'h00);
    bus_wr(2'd2, 8'h89);
    bus_rd(2'd2, v); chk("R8 ctl readback", v, 8'hC9);
    chk("R8 osc_en_o on", {7'd0, osc_en}, 8'h01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule